// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 32 on-chip peripheral sources and drives a single request line towards the host processor. Software programs it through a small synchronous register port that holds four registers. The configuration register holds a global enable, a "favoured source" number and a request-level code for the host. The mask register enables sources one bit each. The in-service register tracks the sources that are being handled. The vector register carries the acknowledge handshake.

Software takes an interrupt in two steps. It writes the vector register with its acknowledge bit set, which latches the winning source number and marks that source in service. It then reads the same register and finds the source number in bits [15:11]. The arbiter picks among sources that are asserted, unmasked and not in service. The favoured source wins first, and after it the lowest source number. A source is only presented if it outranks every source already in service, so nested handling works without extra logic. If the source that raised the request gets masked before software acknowledges it, no source is eligible at acknowledge time. The block then returns the error vector 0 and marks nothing in service, and software just acknowledges and returns.

Top module: `vpic_top`

## Requirements
- R1: After reset the configuration, mask, in-service and vector registers all read 0, and `irq_req` is low whatever the sources do.
- R2: The register port maps configuration to address 0, mask to address 1, in-service to address 2 and vector to address 3. A write to address 1 loads the mask. Mask bit i set to 1 enables source i, and a 0 keeps source i from ever being presented. The mask reads back as written.
- R3: The in-service register is write-one-to-clear. Each 1 in the write data clears that bit, and each 0 leaves its bit unchanged.
- R4: A write to the vector register with bit 0 set is an acknowledge. If a source is eligible, its number is latched and reads back in bits [15:11] (other bits read 0), and its in-service bit is set in the same cycle. A write with bit 0 clear changes neither register.
- R5: An eligible source must be asserted, unmasked and not in service. Among the eligible sources, the source named in configuration bits [12:8] wins first, and after it the lowest source number.
- R6: `irq_req` is high only while configuration bit 7 (global enable) is set and a source would win an acknowledge.
- R7: Priority rank is 0 for the favoured source and n+1 for any other source n, and a lower rank means higher priority. A winner is presented, and granted on acknowledge, only if its rank is strictly below the rank of every in-service source.
- R8: An acknowledge while no source is eligible, for example because the selected source was masked before it was acknowledged, loads the error vector 0 and sets no in-service bit.
- R9: Requests are levels. A source still asserted after its in-service bit is cleared is presented and granted again.
- R10: `irq_level` always equals configuration bits [15:13], and the configuration register reads back bits [15:13], [12:8] and [7] as written, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Level request, one bit per peripheral source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_req | output | 1 | Request to the host processor |
| irq_level | output | 3 | Request-level code for the host, taken from configuration |

## Verification
The directed part drives three sources at once with the favoured field pointing at the highest-numbered of them. This separates favoured-first selection from plain lowest-number order. It then clears the favoured source and raises a lower-numbered source while a mid-rank one is in service, which shows whether the strict-rank nesting rule blocks or admits each one. A pattern that masks the only pending source between request and acknowledge tells the error vector apart from a stale grant. Keeping a source asserted across its in-service clear separates level behaviour from edge capture. A long run of random register writes and sparse random source patterns is then compared against a behavioural model on every clock, which exposes ordering faults that the directed patterns miss.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int MAX_SRC    = 32;
    localparam int SRC_IDX_W  = 5;
    localparam int RANK_W     = 6;
    localparam int DATA_W     = 32;

    // Field positions software depends on
    localparam int CFG_EN_BIT   = 7;
    localparam int CFG_FAV_LSB  = 8;
    localparam int CFG_LVL_LSB  = 13;
    localparam int VEC_LSB      = 11;
    localparam int ACK_BIT      = 0;

    localparam logic [RANK_W-1:0]    RANK_NONE = '1;
    localparam logic [SRC_IDX_W-1:0] ERR_VEC   = '0;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_ISR  = 2'd2,
        SEL_VEC  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2:0]           level;
        logic [SRC_IDX_W-1:0] fav_src;
        logic                 enable;
    } cfg_t;

    // Lower rank means higher priority; favoured source ranks 0.
    function automatic logic [RANK_W-1:0] rank_of(
        input logic [SRC_IDX_W-1:0] idx,
        input logic [SRC_IDX_W-1:0] fav
    );
        if (idx == fav)
            return '0;
        return RANK_W'(idx) + RANK_W'(1);
    endfunction

    function automatic cfg_t cfg_decode(input logic [DATA_W-1:0] d);
        cfg_t c;
        c.level   = d[CFG_LVL_LSB +: 3];
        c.fav_src = d[CFG_FAV_LSB +: SRC_IDX_W];
        c.enable  = d[CFG_EN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_encode(input cfg_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[CFG_LVL_LSB +: 3]         = c.level;
        d[CFG_FAV_LSB +: SRC_IDX_W] = c.fav_src;
        d[CFG_EN_BIT]               = c.enable;
        return d;
    endfunction

endpackage

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   pending,
    input  logic [SRC_IDX_W-1:0] fav_src,
    output logic                 win_valid,
    output logic [SRC_IDX_W-1:0] win_id
);

    logic [MAX_SRC-1:0]   pend_full;
    logic [SRC_IDX_W-1:0] lowest_id;

    assign pend_full = MAX_SRC'(pending);

    always_comb begin
        lowest_id = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i])
                lowest_id = SRC_IDX_W'(i);
        end
    end

    assign win_valid = |pending;
    assign win_id    = pend_full[fav_src] ? fav_src : lowest_id;

    // R5: a winner is always a pending source
    assert_win_pending_R5: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> pend_full[win_id]);

    // R5: favoured source beats any other pending source
    assert_fav_first_R5: assert property (@(posedge clk) disable iff (rst)
        pend_full[fav_src] |-> (win_id == fav_src));

endmodule

// File: rtl/vpic_ceiling.sv
module vpic_ceiling
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   in_service,
    input  logic [SRC_IDX_W-1:0] fav_src,
    output logic [RANK_W-1:0]    ceil_rank
);

    logic [RANK_W-1:0] rank_arr [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
        assign rank_arr[g] = in_service[g] ? rank_of(SRC_IDX_W'(g), fav_src)
                                           : RANK_NONE;
    end

    always_comb begin
        ceil_rank = RANK_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rank_arr[i] < ceil_rank)
                ceil_rank = rank_arr[i];
        end
    end

    // R7: with nothing in service there is no ceiling
    assert_no_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
        (in_service == '0) |-> (ceil_rank == RANK_NONE));

endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [1:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 grant_valid,
    input  logic [SRC_IDX_W-1:0] grant_id,
    output cfg_t                 cfg_q,
    output logic [NUM_SRC-1:0]   mask_q,
    output logic [NUM_SRC-1:0]   isr_q,
    output logic [DATA_W-1:0]    rdata
);

    logic [SRC_IDX_W-1:0] vec_q;
    reg_sel_e             sel;
    logic                 ack_fire;

    assign sel      = reg_sel_e'(addr);
    assign ack_fire = we && (sel == SEL_VEC) && wdata[ACK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
            isr_q  <= '0;
            vec_q  <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_CFG:  cfg_q  <= cfg_decode(wdata);
                SEL_MASK: mask_q <= wdata[NUM_SRC-1:0];
                SEL_ISR:  isr_q  <= isr_q & ~wdata[NUM_SRC-1:0];
                SEL_VEC: begin
                    if (wdata[ACK_BIT]) begin
                        if (grant_valid) begin
                            vec_q           <= grant_id;
                            isr_q[grant_id] <= 1'b1;
                        end else begin
                            vec_q <= ERR_VEC;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CFG:  rdata = cfg_encode(cfg_q);
            SEL_MASK: rdata[NUM_SRC-1:0] = mask_q;
            SEL_ISR:  rdata[NUM_SRC-1:0] = isr_q;
            SEL_VEC:  rdata[VEC_LSB +: SRC_IDX_W] = vec_q;
            default:  rdata = '0;
        endcase
    end

    // R4: a granted acknowledge marks the winner in service
    assert_grant_marks_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && grant_valid) |=> isr_q[$past(grant_id)]);

    // R4: the latched vector is the granted source
    assert_grant_vector_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && grant_valid) |=> (vec_q == $past(grant_id)));

    // R8: an acknowledge without an eligible source yields the error vector
    assert_error_vector_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !grant_valid) |=> ((vec_q == ERR_VEC) && $stable(isr_q)));

    // R3: written ones are cleared in the in-service register
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_ISR) |=> ((isr_q & $past(wdata[NUM_SRC-1:0])) == '0));

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_req,
    output logic [2:0]         irq_level
);

    cfg_t                 cfg_q;
    logic [NUM_SRC-1:0]   mask_q;
    logic [NUM_SRC-1:0]   isr_q;
    logic [NUM_SRC-1:0]   pending;
    logic                 win_valid;
    logic [SRC_IDX_W-1:0] win_id;
    logic [RANK_W-1:0]    ceil_rank;
    logic                 eligible;

    assign pending = src_req & mask_q & ~isr_q;

    vpic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .grant_valid (eligible),
        .grant_id    (win_id),
        .cfg_q       (cfg_q),
        .mask_q      (mask_q),
        .isr_q       (isr_q),
        .rdata       (reg_rdata)
    );

    vpic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .fav_src   (cfg_q.fav_src),
        .win_valid (win_valid),
        .win_id    (win_id)
    );

    vpic_ceiling #(.NUM_SRC(NUM_SRC)) u_ceil (
        .clk        (clk),
        .rst        (rst),
        .in_service (isr_q),
        .fav_src    (cfg_q.fav_src),
        .ceil_rank  (ceil_rank)
    );

    assign eligible  = win_valid && (rank_of(win_id, cfg_q.fav_src) < ceil_rank);
    assign irq_req   = cfg_q.enable && eligible;
    assign irq_level = cfg_q.level;

    // R6: no host request while globally disabled
    assert_req_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> cfg_q.enable);

    // R2: a request always comes from an unmasked asserted source
    assert_req_unmasked_R2: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((src_req & mask_q) != '0));

    // R1: registers come out of reset cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '0 && isr_q == '0 && !cfg_q.enable));

endmodule

// File: tb/tb_vpic_top.sv
module tb_vpic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_req = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;

    always #5 clk = ~clk;

    vpic_top #(.NUM_SRC(32)) dut (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    // Behavioural reference state
    logic [31:0] m_mask = '0, m_isr = '0;
    logic        m_en = 1'b0;
    logic [4:0]  m_fav = '0, m_vec = '0;
    logic [2:0]  m_lvl = '0;

    int          n_vec = 0, n_bad = 0;
    bit          done = 0;
    logic [31:0] s_rd;
    logic        s_irq;
    logic [31:0] cur_src = '0;

    function automatic int f_rank(int i);
        return (i == int'(m_fav)) ? 0 : i + 1;
    endfunction

    function automatic int f_win(logic [31:0] s);
        logic [31:0] p;
        p = s & m_mask & ~m_isr;
        if (p[m_fav]) return int'(m_fav);
        for (int i = 0; i < 32; i++) if (p[i]) return i;
        return -1;
    endfunction

    function automatic bit f_elig(int w);
        if (w < 0) return 0;
        for (int j = 0; j < 32; j++)
            if (m_isr[j] && f_rank(j) <= f_rank(w)) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] f_rd(logic [1:0] a);
        case (a)
            2'd0: return {16'h0, m_lvl, m_fav, m_en, 7'h0};
            2'd1: return m_mask;
            2'd2: return m_isr;
            default: return {16'h0, m_vec, 11'h0};
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(logic [1:0] a, logic w, logic [31:0] d, logic [31:0] s);
        logic [31:0] n_mask, n_isr;
        logic        n_en;
        logic [4:0]  n_fav, n_vec_v;
        logic [2:0]  n_lvl;
        int          win;
        bit          el;
        @(negedge clk);
        reg_addr = a; reg_we = w; reg_wdata = d; src_req = s;
        #1;
        win = f_win(s);
        el  = f_elig(win);
        chk("R6/R7 irq_req", {31'h0, irq_req}, {31'h0, m_en && el});
        chk("R10 irq_level", {29'h0, irq_level}, {29'h0, m_lvl});
        chk("R2/R3/R4 reg_rdata", reg_rdata, f_rd(a));
        s_rd = reg_rdata; s_irq = irq_req;
        n_mask = m_mask; n_isr = m_isr; n_en = m_en;
        n_fav = m_fav; n_lvl = m_lvl; n_vec_v = m_vec;
        if (w) begin
            case (a)
                2'd0: begin n_lvl = d[15:13]; n_fav = d[12:8]; n_en = d[7]; end
                2'd1: n_mask = d;
                2'd2: n_isr = m_isr & ~d;
                default: if (d[0]) begin
                    if (el) begin n_vec_v = 5'(win); n_isr[win] = 1'b1; end
                    else n_vec_v = 5'd0;
                end
            endcase
        end
        @(posedge clk);
        m_mask = n_mask; m_isr = n_isr; m_en = n_en;
        m_fav = n_fav; m_lvl = n_lvl; m_vec = n_vec_v;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cyc(a, 1'b1, d, cur_src);
    endtask

    task automatic rdchk(logic [1:0] a, logic [31:0] exp, string tag);
        cyc(a, 1'b0, 32'h0, cur_src);
        chk(tag, s_rd, exp);
    endtask

    task automatic irqchk(logic exp, string tag);
        cyc(2'd0, 1'b0, 32'h0, cur_src);
        chk(tag, {31'h0, s_irq}, {31'h0, exp});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything cleared, no request even with all sources asserted
        cur_src = 32'hFFFF_FFFF;
        rdchk(2'd0, 32'h0, "R1 cfg");
        rdchk(2'd1, 32'h0, "R1 mask");
        rdchk(2'd2, 32'h0, "R1 isr");
        rdchk(2'd3, 32'h0, "R1 vec");
        irqchk(1'b0, "R1 irq_req");

        // R10: level field and enable read back, drive irq_level
        wr(2'd0, (32'd5 << 13) | (32'd1 << 7));
        rdchk(2'd0, 32'h0000_A080, "R10 cfg readback");
        chk("R10 irq_level pin", {29'h0, irq_level}, 32'd5);

        // R2: masked source is silent, unmasked source requests
        cur_src = 32'h1 << 4;
        irqchk(1'b0, "R2 masked");
        wr(2'd1, 32'hFFFF_FFFF);
        rdchk(2'd1, 32'hFFFF_FFFF, "R2 mask readback");
        irqchk(1'b1, "R2 unmasked");

        // R6: global enable gates the request
        wr(2'd0, 32'd5 << 13);
        irqchk(1'b0, "R6 disabled");
        wr(2'd0, (32'd5 << 13) | (32'd20 << 8) | (32'd1 << 7));
        irqchk(1'b1, "R6 enabled");

        // R5: favoured source 20 beats 4 and 10
        cur_src = (32'h1 << 4) | (32'h1 << 10) | (32'h1 << 20);
        wr(2'd3, 32'h1);
        rdchk(2'd3, 32'h0000_A000, "R5 favoured wins");
        rdchk(2'd2, 32'h0010_0000, "R4 isr set");
        irqchk(1'b0, "R7 blocked by favoured in service");

        // R3: write-one-to-clear, extra ones on clear bits harmless
        wr(2'd2, (32'h1 << 20) | (32'h1 << 3));
        rdchk(2'd2, 32'h0, "R3 w1c");

        // R9: source 20 still asserted is presented again
        irqchk(1'b1, "R9 re-presented");
        wr(2'd3, 32'h1);
        rdchk(2'd3, 32'h0000_A000, "R9 regranted");
        wr(2'd2, 32'h1 << 20);

        // R5: lowest number wins without the favoured source
        cur_src = (32'h1 << 4) | (32'h1 << 10);
        wr(2'd3, 32'h1);
        rdchk(2'd3, 32'h0000_2000, "R5 lowest wins");
        irqchk(1'b0, "R7 rank of 10 not above 4");
        cur_src = cur_src | (32'h1 << 2);
        irqchk(1'b1, "R7 source 2 nests above 4");
        wr(2'd3, 32'h1);
        rdchk(2'd3, 32'h0000_1000, "R7 nested grant");
        rdchk(2'd2, 32'h0000_0014, "R4 two in service");

        // R4: write without acknowledge bit changes nothing
        wr(2'd3, 32'hFFFF_FFFE);
        rdchk(2'd3, 32'h0000_1000, "R4 no-ack vector");
        rdchk(2'd2, 32'h0000_0014, "R4 no-ack isr");

        // R8: mask race gives the error vector
        wr(2'd2, 32'hFFFF_FFFF);
        cur_src = 32'h1 << 10;
        wr(2'd1, 32'h1 << 10);
        irqchk(1'b1, "R8 request before mask");
        wr(2'd1, 32'h0);
        wr(2'd3, 32'h1);
        rdchk(2'd3, 32'h0, "R8 error vector");
        rdchk(2'd2, 32'h0, "R8 nothing in service");

        // Random phase against the model
        for (int k = 0; k < 4000; k++) begin
            logic [1:0]  a;
            logic [31:0] d;
            a = 2'($urandom % 4);
            case (a)
                2'd2:    d = $urandom & $urandom & $urandom;
                2'd3:    d = 32'($urandom % 4);
                default: d = $urandom;
            endcase
            cyc(a, 1'($urandom % 2), d, $urandom & $urandom);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule